// File: doc/BRIEF.md
# Rotating Four-Bank Row Buffer

The block keeps the last rows of a multi-channel feature map on chip so that a 3x3 convolution engine can read a three-row vertical window without going back to external memory. Storage is split into four banks. Each bank holds one complete row for every channel. At any time three banks form the window, ordered top, middle and bottom. The fourth bank takes the next incoming row.

After start-up the first three rows fill banks 0, 1 and 2, and the buffer reports ready. The next row streams into bank 3 while the window is read. When the engine has finished with a window, it pulses `window_done_i`. The window then moves down by one bank: the old middle becomes top, the old bottom becomes middle, and the newly written row becomes bottom. The bank that drops out of the window becomes the new write bank.

If the engine finishes before the incoming row is complete, the move is held back and a stall flag is raised. The move takes effect by itself as soon as the row completes. Border padding is never stored. Out-of-range columns, and slots the engine flags as padding rows, are forced to zero on the output path.

Top module: `rot_row_buffer`

## Requirements
- R1: After reset, `ready_o`, `stall_o` and `rd_valid_o` are all 0.
- R2: Each complete row is NCH*W accepted writes. Completing the first three rows raises `ready_o` at the clock edge that accepts the last word of the third row. `ready_o` then stays 1 until reset.
- R3: A read request accepted while ready returns `rd_valid_o`=1 on the next cycle, with no valid output otherwise. `top_o`, `mid_o` and `bot_o` hold the addressed channel and column of the three window rows, oldest row on top.
- R4: A `window_done_i` pulse while the write bank holds a complete row moves the window by one row in the same cycle, with no stall. The new window is old middle, old bottom and the just-written row, and the freed bank receives the next row.
- R5: A `window_done_i` pulse while the write bank is incomplete raises `stall_o` on the next cycle. The window does not move while stalled. One cycle after the row's last word is accepted, the window moves and `stall_o` returns to 0.
- R6: A read with column below 0 or at least W (signed `rd_col_i`) returns 0 on all three slots.
- R7: `rd_top_zero_i` forces `top_o` to 0 and `rd_bot_zero_i` forces `bot_o` to 0 for that read, independently of each other.
- R8: Writes arriving while the write bank already holds a complete row are ignored and do not alter the stored row.
- R9: `window_done_i` before `ready_o` is ignored: it raises no stall and does not change the fill sequence.
- R10: The rotation wraps cyclically over the four banks, so the window order stays top, middle, bottom through any number of moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe for one pixel of the incoming row |
| wr_ch_i | input | $clog2(NCH) | Channel of the written pixel |
| wr_col_i | input | $clog2(W) | Column of the written pixel |
| wr_data_i | input | DW | Signed pixel value |
| rd_valid_i | input | 1 | Window read request |
| rd_ch_i | input | $clog2(NCH) | Channel to read |
| rd_col_i | input | $clog2(W)+2 | Signed column to read, -1 and W allowed |
| rd_top_zero_i | input | 1 | Treat the top slot as a padding row |
| rd_bot_zero_i | input | 1 | Treat the bottom slot as a padding row |
| window_done_i | input | 1 | Current window fully consumed |
| ready_o | output | 1 | Three rows loaded, window readable |
| stall_o | output | 1 | Window move waiting on the incoming row |
| rd_valid_o | output | 1 | Read data valid |
| top_o | output | DW | Top window value |
| mid_o | output | DW | Middle window value |
| bot_o | output | DW | Bottom window value |

## Verification
A wrong bank index or a rotation that slips shows at the ports on the very next read after a window move: rows come out in the wrong slot or one row stale. Reads are therefore made right after every move, against rows that each carry a distinct pattern. A row counter that miscounts shows as a move that happens too early or too late, so the bench reads the window on both sides of the stall release. Forced-zero paths are exercised at both column borders and for both padding flags, mixed with random interior reads.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int NBANK = 4;
  typedef logic [1:0] bank_idx_t;
endpackage

// File: rtl/rb_bank.sv
module rb_bank #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int ROW_WORDS = 1024
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_fire_i,
  input  logic      window_done_i,
  output bank_idx_t base_o,
  output bank_idx_t wr_bank_o,
  output logic      full_o,
  output logic      ready_o,
  output logic      stall_o
);
  localparam int CNTW = $clog2(ROW_WORDS + 1);

  logic [CNTW-1:0] cnt_q;
  logic [1:0]      fill_q;
  bank_idx_t       base_q;
  logic            pend_q;
  logic            adv;

  assign full_o    = (cnt_q == CNTW'(ROW_WORDS));
  assign ready_o   = (fill_q == 2'd3);
  assign adv       = ready_o & full_o & (window_done_i | pend_q);
  // during fill base is 0, so the write bank equals the number of rows loaded
  assign wr_bank_o = base_q + fill_q;
  assign base_o    = base_q;
  assign stall_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fill_q <= '0;
      base_q <= '0;
      pend_q <= 1'b0;
    end else if (adv) begin
      base_q <= base_q + 2'd1;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ready_o && window_done_i) pend_q <= 1'b1;
      if (wr_fire_i) begin
        if (!ready_o && cnt_q == CNTW'(ROW_WORDS - 1)) begin
          fill_q <= fill_q + 2'd1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rb_rd_mux.sv
module rb_rd_mux
  import rb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NBANK-1:0][DW-1:0] bank_d_i,
  input  bank_idx_t                base_i,
  input  logic                     zero_top_i,
  input  logic                     zero_bot_i,
  input  logic                     zero_col_i,
  output logic [DW-1:0]            top_o,
  output logic [DW-1:0]            mid_o,
  output logic [DW-1:0]            bot_o
);
  logic [2:0][DW-1:0] slot;

  always_comb begin
    for (int s = 0; s < 3; s++) begin
      slot[s] = bank_d_i[base_i + bank_idx_t'(s)];
    end
  end

  assign top_o = (zero_col_i || zero_top_i) ? '0 : slot[0];
  assign mid_o = zero_col_i                 ? '0 : slot[1];
  assign bot_o = (zero_col_i || zero_bot_i) ? '0 : slot[2];
endmodule

// File: rtl/rot_row_buffer.sv
module rot_row_buffer
  import rb_pkg::*;
#(
  parameter int NCH = 16,
  parameter int W   = 64,
  parameter int DW  = 8,
  localparam int CHW   = $clog2(NCH),
  localparam int CW    = $clog2(W),
  localparam int WORDS = NCH * W,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [CHW-1:0]       wr_ch_i,
  input  logic [CW-1:0]        wr_col_i,
  input  logic signed [DW-1:0] wr_data_i,
  input  logic                 rd_valid_i,
  input  logic [CHW-1:0]       rd_ch_i,
  input  logic signed [CW+1:0] rd_col_i,
  input  logic                 rd_top_zero_i,
  input  logic                 rd_bot_zero_i,
  input  logic                 window_done_i,
  output logic                 ready_o,
  output logic                 stall_o,
  output logic                 rd_valid_o,
  output logic signed [DW-1:0] top_o,
  output logic signed [DW-1:0] mid_o,
  output logic signed [DW-1:0] bot_o
);
  bank_idx_t base, wr_bank, base_rq;
  logic      full, wr_fire, rd_fire, col_oob;
  logic      zt_q, zb_q, zc_q, rv_q;
  logic [AW-1:0] waddr, raddr;
  logic [NBANK-1:0][DW-1:0] bank_d;
  logic [DW-1:0] top_w, mid_w, bot_w;

  assign wr_fire = wr_valid_i & ~full & (32'(wr_ch_i) < NCH) & (32'(wr_col_i) < W);
  assign rd_fire = rd_valid_i & ready_o;
  assign col_oob = rd_col_i[CW+1] || (rd_col_i[CW:0] >= (CW+1)'(W)) || (32'(rd_ch_i) >= NCH);
  assign waddr   = AW'(wr_ch_i) * AW'(W) + AW'(wr_col_i);
  assign raddr   = AW'(rd_ch_i) * AW'(W) + AW'(rd_col_i[CW-1:0]);

  rb_ctrl #(.ROW_WORDS(WORDS)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_fire_i(wr_fire), .window_done_i,
    .base_o(base), .wr_bank_o(wr_bank),
    .full_o(full), .ready_o, .stall_o
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rb_bank #(.DEPTH(WORDS), .DW(DW)) u_bank (
      .clk_i,
      .we_i(wr_fire && wr_bank == bank_idx_t'(b)),
      .waddr_i(waddr), .wdata_i(wr_data_i),
      .raddr_i(raddr), .rdata_o(bank_d[b])
    );
  end

  // read-side sidebands aligned with the registered bank data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q <= 1'b0; base_rq <= '0;
      zt_q <= 1'b0; zb_q <= 1'b0; zc_q <= 1'b0;
    end else begin
      rv_q <= rd_fire;
      if (rd_fire) begin
        base_rq <= base;
        zt_q <= rd_top_zero_i;
        zb_q <= rd_bot_zero_i;
        zc_q <= col_oob;
      end
    end
  end

  rb_rd_mux #(.DW(DW)) u_mux (
    .bank_d_i(bank_d), .base_i(base_rq),
    .zero_top_i(zt_q), .zero_bot_i(zb_q), .zero_col_i(zc_q),
    .top_o(top_w), .mid_o(mid_w), .bot_o(bot_w)
  );

  assign rd_valid_o = rv_q;
  assign top_o = top_w;
  assign mid_o = mid_w;
  assign bot_o = bot_w;
endmodule

// File: rtl/rot_row_buffer_chk.sv
module rot_row_buffer_chk #(
  parameter int W  = 64,
  parameter int CW = 6,
  parameter int DW = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rd_valid_i,
  input logic signed [CW+1:0] rd_col_i,
  input logic                 rd_top_zero_i,
  input logic                 rd_bot_zero_i,
  input logic                 ready_o,
  input logic                 stall_o,
  input logic                 rd_valid_o,
  input logic [DW-1:0]        top_o,
  input logic [DW-1:0]        mid_o,
  input logic [DW-1:0]        bot_o
);
  logic oob;
  assign oob = (rd_col_i < 0) || (rd_col_i >= (CW+2)'(W));

  p_rd_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && ready_o) |=> rd_valid_o);
  p_no_spurious_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_i && ready_o) |=> !rd_valid_o);
  p_ready_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  p_pad_col_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && ready_o && oob) |=> (top_o == '0 && mid_o == '0 && bot_o == '0));
  p_zero_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && ready_o && rd_top_zero_i) |=> (top_o == '0));
  p_zero_bot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && ready_o && rd_bot_zero_i) |=> (bot_o == '0));
  p_stall_needs_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ready_o);
endmodule

bind rot_row_buffer rot_row_buffer_chk #(.W(W), .CW(CW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rd_valid_i(rd_valid_i), .rd_col_i(rd_col_i),
  .rd_top_zero_i(rd_top_zero_i), .rd_bot_zero_i(rd_bot_zero_i),
  .ready_o(ready_o), .stall_o(stall_o), .rd_valid_o(rd_valid_o),
  .top_o(top_o), .mid_o(mid_o), .bot_o(bot_o)
);

// File: tb/rot_row_buffer_bench.sv
module rot_row_buffer_bench;
  localparam int NCH = 16;
  localparam int W   = 64;
  localparam int DW  = 8;
  localparam int CHW = $clog2(NCH);
  localparam int CW  = $clog2(W);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid = 1'b0;
  logic [CHW-1:0] wr_ch = '0;
  logic [CW-1:0] wr_col = '0;
  logic signed [DW-1:0] wr_data = '0;
  logic rd_valid = 1'b0;
  logic [CHW-1:0] rd_ch = '0;
  logic signed [CW+1:0] rd_col = '0;
  logic rd_tz = 1'b0, rd_bz = 1'b0, win_done = 1'b0;
  logic ready, stall, rvalid;
  logic signed [DW-1:0] top, mid, bot;

  int checks = 0, fails = 0, top_row = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rot_row_buffer #(.NCH(NCH), .W(W), .DW(DW)) u_rot_row_buffer (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_ch_i(wr_ch), .wr_col_i(wr_col), .wr_data_i(wr_data),
    .rd_valid_i(rd_valid), .rd_ch_i(rd_ch), .rd_col_i(rd_col),
    .rd_top_zero_i(rd_tz), .rd_bot_zero_i(rd_bz), .window_done_i(win_done),
    .ready_o(ready), .stall_o(stall), .rd_valid_o(rvalid),
    .top_o(top), .mid_o(mid), .bot_o(bot)
  );

  function automatic logic [DW-1:0] pix(int row, int ch, int col);
    return DW'((row * 73 + ch * 29 + col * 7 + 13) ^ (row << 3));
  endfunction

  task automatic chk(bit ok, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic put(int ch, int col, logic [DW-1:0] d);
    wr_valid = 1'b1; wr_ch = CHW'(ch); wr_col = CW'(col); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // row-major stream, channels innermost; words [from, to) of the row
  task automatic write_part(int row, int from, int to);
    for (int k = from; k < to; k++) begin
      if ($urandom % 4 == 0) @(negedge clk);
      put(k % NCH, k / NCH, pix(row, k % NCH, k / NCH));
    end
  endtask

  task automatic write_row(int row);
    write_part(row, 0, NCH * W);
  endtask

  task automatic do_read(int ch, int col, bit tz, bit bz, string req);
    logic [DW-1:0] et, em, eb;
    bit oob;
    oob = (col < 0) || (col >= W);
    et = (oob || tz) ? '0 : pix(top_row, ch, col);
    em = oob ? '0 : pix(top_row + 1, ch, col);
    eb = (oob || bz) ? '0 : pix(top_row + 2, ch, col);
    rd_valid = 1'b1; rd_ch = CHW'(ch); rd_col = (CW+2)'(col); rd_tz = tz; rd_bz = bz;
    @(negedge clk);
    rd_valid = 1'b0; rd_tz = 1'b0; rd_bz = 1'b0;
    chk(rvalid === 1'b1 && top === et && mid === em && bot === eb,
        $sformatf("%s ch=%0d col=%0d v=%b got %h/%h/%h exp 1 %h/%h/%h",
                  req, ch, col, rvalid, top, mid, bot, et, em, eb));
  endtask

  task automatic rand_reads(int n, string req);
    for (int i = 0; i < n; i++) begin
      int c;
      c = int'($urandom % (W + 2)) - 1;
      do_read(int'($urandom % NCH), c, ($urandom % 5) == 0, ($urandom % 5) == 0, req);
    end
  endtask

  task automatic pulse_done();
    win_done = 1'b1;
    @(negedge clk);
    win_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ready === 1'b0 && stall === 1'b0 && rvalid === 1'b0,
        $sformatf("R1 reset got %b%b%b exp 000", ready, stall, rvalid));
    rst_ni = 1'b1;
    @(negedge clk);

    write_row(0);
    chk(ready === 1'b0, $sformatf("R2 ready after row 0 got %b exp 0", ready));
    pulse_done();
    chk(stall === 1'b0, $sformatf("R9 early window_done got stall %b exp 0", stall));
    write_row(1);
    chk(ready === 1'b0, $sformatf("R2 ready after row 1 got %b exp 0", ready));
    write_part(2, 0, NCH * W - 1);
    chk(ready === 1'b0, $sformatf("R9 ready one word short got %b exp 0", ready));
    write_part(2, NCH * W - 1, NCH * W);
    chk(ready === 1'b1, $sformatf("R2 ready after row 2 got %b exp 1", ready));

    // directed window reads and borders
    do_read(0, 0, 0, 0, "R3");
    do_read(NCH - 1, W - 1, 0, 0, "R3");
    do_read(5, -1, 0, 0, "R6");
    do_read(7, W, 0, 0, "R6");
    do_read(3, 10, 1, 0, "R7");
    do_read(3, 11, 0, 1, "R7");
    do_read(9, 20, 1, 1, "R7");
    rand_reads(30, "R3");

    // stall: row 3 half written when window is done
    write_part(3, 0, NCH * W / 2);
    pulse_done();
    chk(stall === 1'b1, $sformatf("R5 stall raise got %b exp 1", stall));
    do_read(2, 30, 0, 0, "R5");
    write_part(3, NCH * W / 2, NCH * W);
    chk(stall === 1'b1, $sformatf("R5 stall at last word got %b exp 1", stall));
    @(negedge clk);
    top_row = 1;
    chk(stall === 1'b0, $sformatf("R5 stall release got %b exp 0", stall));
    do_read(4, 33, 0, 0, "R5");
    rand_reads(10, "R4");

    // extra writes into a complete write bank
    write_row(4);
    for (int i = 0; i < 40; i++)
      put(int'($urandom % NCH), int'($urandom % W), ~pix(4, i, i));
    chk(stall === 1'b0, $sformatf("R8 no stall got %b exp 0", stall));
    pulse_done();
    top_row = 2;
    chk(stall === 1'b0, $sformatf("R4 no stall on full row got %b exp 0", stall));
    rand_reads(30, "R8");

    // many moves so the rotation wraps several times
    for (int r = 5; r < 13; r++) begin
      write_row(r);
      pulse_done();
      top_row = r - 2;
      do_read(0, 0, 0, 0, "R10");
      do_read(NCH - 1, W - 1, 0, 0, "R10");
      rand_reads(6, "R4");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule